// File: doc/BRIEF.md
# Crank Signal Speed and Sync Unit

This unit turns the raw crank position sensor into three things the engine sequencer needs: a one-cycle pulse when the first-cylinder marker on the trigger wheel passes, the number of clock ticks between two such markers, and the engine speed derived from that interval. It is meant to run from a slow system clock, nominally 100 kHz, so one tick is 10 us. The speed constant is chosen so that speed = 6,000,000 / ticks.

The raw input first goes through a majority filter over the last eight samples. The filtered level only flips when the window clearly disagrees with the present level, so a lone spike or dropout never produces an edge. Each accepted rising edge is time-stamped by a tick counter. The unit keeps the three most recent edge-to-edge gaps. The marker, such as a missing tooth, is recognised when the middle gap is more than one and a half times both of its neighbours. A sequential divider then converts the cycle interval into speed without a wide combinational divide. When no edge arrives for 65535 ticks, the tick counter saturates, a stall flag rises and all sync history is dropped.

The sync tracker is a four-state machine. SY_IDLE means no reference edge is held. SY_FILL means a reference edge is held and fewer than three gaps are stored. SY_HUNT means three gaps are held but no marker has been seen. SY_LOCK means a marker has been seen. The transitions are as follows:
- idle-to-fill on any edge.
- fill-to-fill on the first and second gap.
- fill-to-hunt on the third gap without a marker.
- fill-to-lock or hunt-to-lock on a gap that completes a marker.
- lock-to-lock on any further edge.
- any-to-idle on stall.
- any-to-fill when an edge coincides with stall.

The divider has three states. DV_IDLE waits. DV_RUN produces one quotient bit per tick. DV_DONE publishes the result. The transitions are as follows:
- idle-to-run on a start with a non-zero divisor.
- idle-to-done on a start with a zero divisor.
- run-to-done after the last bit.
- done-to-idle.
- any-to-run on a new start.

Top module: `crank_sync_unit`

## Requirements
- R1: While and directly after reset, sync_pulse, stall and rpm_valid are 0, and cycle_time and rpm are 0.
- R2: The filtered level rises only when at least 6 of the last 8 raw samples are 1 and the level is low. It falls only when at least 6 of the last 8 samples are 0 and the level is high. A single-sample spike in a low phase or dropout in a high phase of at least 8 samples leaves all measured intervals unchanged.
- R3: Only rising edges of the filtered level are timed. The gap of an edge is the number of ticks since the previous accepted edge, so a clean raw signal with rising edges G ticks apart gives gaps of G.
- R4: sync_pulse is a one-tick pulse, one tick after the edge that completes three stored gaps (old, mid, new), asserted exactly when 2*mid > 3*old and 2*mid > 3*new. A middle gap of exactly 1.5 times its neighbours gives no pulse.
- R5: cycle_time is loaded, at each sync_pulse that has an earlier sync since reset or stall, with the number of ticks since that earlier sync_pulse. It holds its value otherwise.
- R6: After each cycle_time load, rpm becomes floor(RPM_NUM / cycle_time) with RPM_NUM = 6,000,000 by default, and rpm_valid pulses for one tick in the same cycle. A divisor of 0 gives rpm 0. rpm holds between pulses.
- R7: The first sync_pulse after reset, and the first after a stall, loads neither cycle_time nor rpm.
- R8: When 65535 ticks pass with no accepted edge, stall goes to 1 and stays 1 until the next accepted edge. The stored gaps are dropped, so the first edge after a stall serves only as the new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System tick clock |
| rst | input | 1 | Synchronous active-high reset |
| crank_raw | input | 1 | Raw crank sensor level |
| sync_pulse | output | 1 | One-tick first-cylinder marker pulse |
| stall | output | 1 | No edge for the full tick-counter range |
| cycle_time | output | CYC_W (24) | Ticks between the last two sync pulses |
| rpm | output | RPM_W (23) | Engine speed, RPM_NUM / cycle_time |
| rpm_valid | output | 1 | One-tick strobe when rpm is updated |

## Verification
The bench builds the unit with its defaults: an 8-sample window with an agreement count of 6, a 16-bit tick counter and a 24-bit cycle counter. The 16-bit counter lets the 65535-tick stall limit be reached, and also lets a full resync after a stall be seen, well inside the run. Trigger wheels with 3 to 12 teeth, one of them missing, and tooth periods of 16 to 60 ticks give cycle intervals up to 720 ticks. These drive the divider over quotients from about 8,000 to over 100,000. Directed gap triples of 20/30/20 and 20/31/20 place the marker ratio on both sides of the strict 1.5 threshold.

// File: rtl/crank_pkg.sv
package crank_pkg;

    typedef enum logic [1:0] {
        SY_IDLE,
        SY_FILL,
        SY_HUNT,
        SY_LOCK
    } sync_state_t;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_DONE
    } div_state_t;

endpackage

// File: rtl/crank_filter.sv
module crank_filter #(
    parameter int WIN   = 8,
    parameter int AGREE = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic rise
);
    localparam int CW = $clog2(WIN + 1);

    logic [WIN-1:0] win;
    logic [CW-1:0]  ones;
    logic [CW-1:0]  zeros;

    always_comb begin
        ones  = CW'($countones(win));
        zeros = CW'(WIN) - ones;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win   <= '0;
            level <= 1'b0;
            rise  <= 1'b0;
        end else begin
            win  <= {win[WIN-2:0], raw};
            rise <= 1'b0;
            if (!level && ones >= CW'(AGREE)) begin
                level <= 1'b1;
                rise  <= 1'b1;
            end else if (level && zeros >= CW'(AGREE)) begin
                level <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crank_gap_track.sv
module crank_gap_track
    import crank_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_in,
    output logic sync_pulse,
    output logic stall
);
    localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};
    localparam int MW = TS_W + 3;

    sync_state_t     state, state_n;
    logic [1:0]      fill_cnt, fill_n;
    logic [TS_W-1:0] gap_cnt;
    logic [TS_W-1:0] hist [3];
    logic [TS_W-1:0] d_old, d_mid, d_new;
    logic [MW-1:0]   two_mid, three_old, three_new;
    logic            stall_now, push, test, marker;

    assign stall_now = (gap_cnt == TS_MAX);
    assign stall     = stall_now;

    always_comb begin
        d_old     = hist[1];
        d_mid     = hist[2];
        d_new     = gap_cnt + 1'b1;
        two_mid   = {2'b0, d_mid, 1'b0};
        three_old = {3'b0, d_old} + {2'b0, d_old, 1'b0};
        three_new = {3'b0, d_new} + {2'b0, d_new, 1'b0};
        marker    = (two_mid > three_old) && (two_mid > three_new);
    end

    always_comb begin
        state_n = state;
        fill_n  = fill_cnt;
        push    = 1'b0;
        test    = 1'b0;
        if (edge_in && stall_now) begin
            state_n = SY_FILL;
            fill_n  = 2'd0;
        end else if (stall_now) begin
            state_n = SY_IDLE;
        end else if (edge_in) begin
            unique case (state)
                SY_IDLE: begin
                    state_n = SY_FILL;
                    fill_n  = 2'd0;
                end
                SY_FILL: begin
                    push = 1'b1;
                    if (fill_cnt == 2'd2) begin
                        test    = 1'b1;
                        state_n = marker ? SY_LOCK : SY_HUNT;
                    end else begin
                        fill_n = fill_cnt + 2'd1;
                    end
                end
                SY_HUNT: begin
                    push = 1'b1;
                    test = 1'b1;
                    if (marker) state_n = SY_LOCK;
                end
                SY_LOCK: begin
                    push = 1'b1;
                    test = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SY_IDLE;
            fill_cnt <= 2'd0;
        end else begin
            state    <= state_n;
            fill_cnt <= fill_n;
        end
    end

    // outputs, timestamp and gap history
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt    <= '0;
            sync_pulse <= 1'b0;
            for (int i = 0; i < 3; i++) hist[i] <= '0;
        end else begin
            sync_pulse <= test && marker;
            if (edge_in)         gap_cnt <= '0;
            else if (!stall_now) gap_cnt <= gap_cnt + 1'b1;
            if (push) begin
                hist[0] <= hist[1];
                hist[1] <= hist[2];
                hist[2] <= d_new;
            end
        end
    end

endmodule

// File: rtl/crank_cycle.sv
module crank_cycle #(
    parameter int CYC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             lost,
    output logic [CYC_W-1:0] cycle_time,
    output logic             start
);
    localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

    logic [CYC_W-1:0] cyc_cnt;
    logic             have_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_cnt    <= '0;
            have_ref   <= 1'b0;
            cycle_time <= '0;
            start      <= 1'b0;
        end else begin
            start <= 1'b0;
            if (sync_in) begin
                cyc_cnt  <= '0;
                have_ref <= 1'b1;
                if (have_ref) begin
                    cycle_time <= (cyc_cnt == CYC_MAX) ? CYC_MAX : cyc_cnt + 1'b1;
                    start      <= 1'b1;
                end
            end else begin
                if (cyc_cnt != CYC_MAX) cyc_cnt <= cyc_cnt + 1'b1;
                if (lost) have_ref <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crank_rpm_div.sv
module crank_rpm_div
    import crank_pkg::*;
#(
    parameter int NUM   = 6_000_000,
    parameter int NUM_W = 23,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEN_W-1:0] divisor,
    output logic [NUM_W-1:0] result,
    output logic             valid
);
    localparam int CNT_W = $clog2(NUM_W);
    localparam logic [NUM_W-1:0] NUM_C = NUM_W'(NUM);

    div_state_t       state;
    logic [CNT_W-1:0] bit_idx;
    logic [DEN_W-1:0] den, rem;
    logic [NUM_W-1:0] quo;
    logic [DEN_W:0]   trial;

    assign trial = {rem, NUM_C[bit_idx]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DV_IDLE;
            bit_idx <= '0;
            den     <= '0;
            rem     <= '0;
            quo     <= '0;
            result  <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                den     <= divisor;
                rem     <= '0;
                quo     <= '0;
                bit_idx <= CNT_W'(NUM_W - 1);
                state   <= (divisor == '0) ? DV_DONE : DV_RUN;
            end else begin
                unique case (state)
                    DV_IDLE: ;
                    DV_RUN: begin
                        if (trial >= {1'b0, den}) begin
                            rem <= DEN_W'(trial - {1'b0, den});
                            quo <= {quo[NUM_W-2:0], 1'b1};
                        end else begin
                            rem <= trial[DEN_W-1:0];
                            quo <= {quo[NUM_W-2:0], 1'b0};
                        end
                        if (bit_idx == '0) state <= DV_DONE;
                        else bit_idx <= bit_idx - 1'b1;
                    end
                    DV_DONE: begin
                        result <= quo;
                        valid  <= 1'b1;
                        state  <= DV_IDLE;
                    end
                    default: state <= DV_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/crank_sync_unit.sv
module crank_sync_unit #(
    parameter int WIN     = 8,
    parameter int AGREE   = 6,
    parameter int TS_W    = 16,
    parameter int CYC_W   = 24,
    parameter int RPM_NUM = 6_000_000,
    parameter int RPM_W   = $clog2(RPM_NUM + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             crank_raw,
    output logic             sync_pulse,
    output logic             stall,
    output logic [CYC_W-1:0] cycle_time,
    output logic [RPM_W-1:0] rpm,
    output logic             rpm_valid
);
    logic filt_level;
    logic edge_evt;
    logic div_start;

    crank_filter #(.WIN(WIN), .AGREE(AGREE)) u_filter (
        .clk   (clk),
        .rst   (rst),
        .raw   (crank_raw),
        .level (filt_level),
        .rise  (edge_evt)
    );

    crank_gap_track #(.TS_W(TS_W)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .edge_in    (edge_evt),
        .sync_pulse (sync_pulse),
        .stall      (stall)
    );

    crank_cycle #(.CYC_W(CYC_W)) u_cycle (
        .clk        (clk),
        .rst        (rst),
        .sync_in    (sync_pulse),
        .lost       (stall),
        .cycle_time (cycle_time),
        .start      (div_start)
    );

    crank_rpm_div #(.NUM(RPM_NUM), .NUM_W(RPM_W), .DEN_W(CYC_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start   (div_start),
        .divisor (cycle_time),
        .result  (rpm),
        .valid   (rpm_valid)
    );

endmodule

// File: rtl/crank_sync_unit_checker.sv
module crank_sync_unit_checker #(
    parameter int CYC_W = 24,
    parameter int RPM_W = 23
) (
    input logic             clk,
    input logic             rst,
    input logic             edge_evt,
    input logic             filt_level,
    input logic             sync_pulse,
    input logic             stall,
    input logic [CYC_W-1:0] cycle_time,
    input logic [RPM_W-1:0] rpm,
    input logic             rpm_valid
);
    p_edge_rise_r2: assert property (@(posedge clk) disable iff (rst)
        edge_evt |-> $rose(filt_level));

    p_sync_after_edge_r4: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> $past(edge_evt));

    p_sync_single_r4: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);

    p_cycle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !sync_pulse |=> $stable(cycle_time));

    p_rpm_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !rpm_valid |-> $stable(rpm));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        rpm_valid |=> !rpm_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (stall && !edge_evt) |=> stall);

    p_stall_clear_r8: assert property (@(posedge clk) disable iff (rst)
        edge_evt |=> !stall);

endmodule

bind crank_sync_unit crank_sync_unit_checker #(.CYC_W(CYC_W), .RPM_W(RPM_W)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .edge_evt   (edge_evt),
    .filt_level (filt_level),
    .sync_pulse (sync_pulse),
    .stall      (stall),
    .cycle_time (cycle_time),
    .rpm        (rpm),
    .rpm_valid  (rpm_valid)
);

// File: tb/crank_sync_unit_bench.sv
module crank_sync_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        crank_raw = 1'b0;
    logic        sync_pulse, stall, rpm_valid;
    logic [23:0] cycle_time;
    logic [22:0] rpm;

    int total = 0;
    int bad   = 0;
    int sync_cnt = 0;
    int meas_cnt = 0;
    int last_rpm = 0;
    int last_cyc = 0;

    always #4 clk = ~clk;

    crank_sync_unit u_crank_sync_unit (
        .clk        (clk),
        .rst        (rst),
        .crank_raw  (crank_raw),
        .sync_pulse (sync_pulse),
        .stall      (stall),
        .cycle_time (cycle_time),
        .rpm        (rpm),
        .rpm_valid  (rpm_valid)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sync_pulse) sync_cnt++;
            if (rpm_valid) begin
                meas_cnt++;
                last_rpm = int'(rpm);
                last_cyc = int'(cycle_time);
            end
        end
    end

    function automatic int exp_rpm(int cyc);
        return (cyc == 0) ? 0 : 6000000 / cyc;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v);
        @(negedge clk);
        crank_raw = v;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        crank_raw = 1'b0;
        idle(4);
        sync_cnt = 0;
        meas_cnt = 0;
        last_rpm = 0;
        last_cyc = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one tooth: high half, low half; optional one-sample spike/dropout
    task automatic tooth(int p, bit gl);
        int hi = p / 2;
        int lo = p - hi;
        for (int i = 0; i < hi; i++) step((gl && i == hi - 2) ? 1'b0 : 1'b1);
        for (int i = 0; i < lo; i++) step(gl && i == 2);
    endtask

    task automatic wheel(int t, int p, int revs, bit gl);
        for (int r = 0; r < revs; r++) begin
            for (int k = 0; k < t - 1; k++) tooth(p, gl);
            idle(p);
        end
    endtask

    task automatic gap_pulse(int g);
        for (int i = 0; i < 8; i++) step(1'b1);
        idle(g - 8);
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        int t, p, revs, cyc, b_sync, b_meas;
        bit gl;
        seed = $urandom(1234);

        // R1 reset state
        do_reset();
        @(negedge clk);
        check(!sync_pulse && !stall && !rpm_valid, "R1 flags", int'({sync_pulse, stall, rpm_valid}), 0);
        check(cycle_time == 0 && rpm == 0, "R1 values", int'(cycle_time) + int'(rpm), 0);

        // R3 R5 R6 R7 clean missing-tooth wheel
        do_reset();
        wheel(6, 20, 4, 1'b0);
        idle(100);
        check(sync_cnt == 3, "R4 sync count clean", sync_cnt, 3);
        check(meas_cnt == 2, "R7 first sync no update", meas_cnt, 2);
        check(last_cyc == 120, "R3 R5 cycle clean", last_cyc, 120);
        check(last_rpm == 50000, "R6 rpm clean", last_rpm, 50000);

        // R2 glitches change nothing
        do_reset();
        wheel(8, 24, 3, 1'b1);
        idle(100);
        check(sync_cnt == 2, "R2 sync count glitched", sync_cnt, 2);
        check(last_cyc == 192, "R2 cycle glitched", last_cyc, 192);
        check(last_rpm == exp_rpm(192), "R2 rpm glitched", last_rpm, exp_rpm(192));

        // R4 threshold exactly 1.5: no sync
        do_reset();
        gap_pulse(20); gap_pulse(30); gap_pulse(20); gap_pulse(20);
        idle(30);
        check(sync_cnt == 0, "R4 ratio 1.5 no sync", sync_cnt, 0);

        // R4 just above 1.5: one sync, R7 no update
        do_reset();
        gap_pulse(20); gap_pulse(31); gap_pulse(20); gap_pulse(20);
        idle(60);
        check(sync_cnt == 1, "R4 ratio above 1.5 sync", sync_cnt, 1);
        check(meas_cnt == 0 && cycle_time == 0, "R7 lone sync no load", meas_cnt + int'(cycle_time), 0);

        // random wheels
        for (int n = 0; n < 6; n++) begin
            t    = $urandom_range(12, 3);
            p    = $urandom_range(60, 16);
            revs = $urandom_range(4, 3);
            gl   = 1'($urandom_range(1, 0));
            cyc  = t * p;
            do_reset();
            wheel(t, p, revs, gl);
            idle(100);
            check(sync_cnt == revs - 1, "R4 random sync count", sync_cnt, revs - 1);
            check(meas_cnt == revs - 2, "R7 random update count", meas_cnt, revs - 2);
            check(last_cyc == cyc, "R5 random cycle", last_cyc, cyc);
            check(last_rpm == exp_rpm(cyc), "R6 random rpm", last_rpm, exp_rpm(cyc));
        end

        // R8 stall and resync
        do_reset();
        wheel(4, 20, 3, 1'b0);
        check(meas_cnt == 1 && last_cyc == 80, "R5 pre-stall cycle", last_cyc, 80);
        check(last_rpm == 75000, "R6 pre-stall rpm", last_rpm, 75000);
        idle(65000);
        check(stall == 1'b0, "R8 no stall before limit", int'(stall), 0);
        idle(600);
        check(stall == 1'b1, "R8 stall after limit", int'(stall), 1);
        b_sync = sync_cnt;
        b_meas = meas_cnt;
        wheel(4, 20, 3, 1'b0);
        idle(100);
        check(stall == 1'b0, "R8 stall cleared by edge", int'(stall), 0);
        check(sync_cnt - b_sync == 2, "R8 resync count", sync_cnt - b_sync, 2);
        check(meas_cnt - b_meas == 1, "R7 R8 first sync after stall", meas_cnt - b_meas, 1);
        check(last_cyc == 80, "R8 cycle after resync", last_cyc, 80);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule